// File: doc/BRIEF.md
# Erase-Block Write Lock Manager

This block holds the write-protection state of every erase block in a boot-block style flash array. A command decoder upstream hands it lock, unlock and lock-down requests, each with a word address. The upper address bits select the block. Program and erase sequencers ask it whether the block they target may be written. Identifier-mode reads ask it for a status word that describes a block's lock state.

Each block is in one of three states: unlocked, locked, or locked-down. A lock-down is held in a separate sticky attribute that only reset can clear. While the active-low hardware protect pin `wp_n` is low, a locked-down block is forced locked and unlock requests to it are ignored. While `wp_n` is high, such a block can be unlocked and relocked freely. It falls back to locked as soon as `wp_n` goes low again, and no command is needed for that. Every block comes out of reset locked.

The state lives in flops. A command changes it on the clock edge that accepts the command. Both query ports are registered and answer one cycle after their address is presented.

Top module: `blk_lock_mgr`

## Requirements
- R1: A synchronous reset (`rst` high) puts every block in the locked state with its lock-down attribute clear. In the cycle after reset, `chk_allow` is 0 and `rd_status` is 0x0001.
- R2: Op code 1 locks the addressed block. Op code 2 unlocks it when it has no lock-down attribute. An unlocked block reports `chk_allow` = 1 and `rd_status` = 0x0000.
- R3: Op code 3 locks the addressed block and sets its lock-down attribute. It then reports `rd_status` = 0x0003 and `chk_allow` = 0.
- R4: An unlock request to a block with the lock-down attribute is ignored while `wp_n` is 0. The block keeps status 0x0003.
- R5: While `wp_n` is 1, a block with the lock-down attribute can be unlocked (status 0x0002, `chk_allow` = 1) and relocked (status 0x0003).
- R6: When `wp_n` is 0, every block with the lock-down attribute reads as locked, whatever unlock it received while `wp_n` was 1. This needs no command.
- R7: The lock-down attribute (status bit 1) is cleared only by reset. Lock and unlock requests leave it set.
- R8: A request accepted at a clock edge is seen by any query sampled at the next edge or later. A query sampled at the same edge as the request sees the old state. Query outputs appear one cycle after their address is sampled.
- R9: No state changes when `cmd_valid` is 0, and none for op code 0 while `cmd_valid` is 1.
- R10: A block index (address bits [ADDR_W-1 -: IDX_W]) of NUM_BLOCKS or above addresses no block. Requests to it change nothing, and queries to it return `chk_allow` = 0 and `rd_status` = 0x0001.
- R11: Status word encoding: bit 0 is the effective lock, bit 1 is the lock-down attribute, and bits STAT_W-1..2 are zero. Address bits below the block index are ignored.
- R12: The permission port and the status port work independently. When both are given the same address, they agree: `chk_allow` equals the inverse of status bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Lock request strobe |
| cmd_op | input | 2 | 0 none, 1 lock, 2 unlock, 3 lock-down |
| cmd_addr | input | ADDR_W | Word address of the request; upper bits pick the block |
| wp_n | input | 1 | Hardware write protect, active low |
| chk_addr | input | ADDR_W | Address for the program/erase permission query |
| chk_allow | output | 1 | Registered: 1 when that block may be programmed or erased |
| rd_addr | input | ADDR_W | Address for the identifier-mode status query |
| rd_status | output | STAT_W | Registered lock status word of that block |

## Verification
The bound assertions check the following on every cycle:
- the reset values of both outputs;
- that a block showing the lock-down attribute reads locked whenever `wp_n` was low;
- that the lock-down attribute never disappears from a block watched at a steady address;
- that out-of-range indices are always refused;
- that the two query ports agree on a shared address.

Other behaviours depend on a history of requests and pin changes, so only the bench's scenarios can show them. These are: an ignored unlock under protection, an unlock and relock with the pin high, the fall back to locked when the pin drops, the one-edge ordering between a request and a query, and the clearing of lock-down by reset.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

  typedef enum logic [1:0] {
    LOP_NONE     = 2'd0,
    LOP_LOCK     = 2'd1,
    LOP_UNLOCK   = 2'd2,
    LOP_LOCKDOWN = 2'd3
  } lock_op_e;

endpackage

// File: rtl/blk_lock_dec.sv
module blk_lock_dec #(
  parameter int NUM_BLOCKS = 12,
  parameter int ADDR_W     = 20
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic [NUM_BLOCKS-1:0] hit,
  output logic                  in_range
);
  localparam int IDX_W = $clog2(NUM_BLOCKS);

  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_W-1 -: IDX_W];

  // one-hot select per block; an index past the last block selects nothing
  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_hit
    assign hit[g] = (idx == IDX_W'(g));
  end

  assign in_range = |hit;
endmodule

// File: rtl/blk_lock_cell.sv
module blk_lock_cell
  import blk_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic [1:0] op,
  input  logic       wp_n,
  output logic       eff_lock,
  output logic       down
);
  logic lk_q;
  logic ld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_q <= 1'b1;
      ld_q <= 1'b0;
    end else if (sel) begin
      unique case (lock_op_e'(op))
        LOP_LOCK:     lk_q <= 1'b1;
        LOP_LOCKDOWN: begin
          lk_q <= 1'b1;
          ld_q <= 1'b1;
        end
        LOP_UNLOCK:   if (!ld_q || wp_n) lk_q <= 1'b0;
        default:      ;
      endcase
    end
  end

  // a lock-down block is forced locked while the pin protects it
  assign eff_lock = lk_q | (ld_q & ~wp_n);
  assign down     = ld_q;
endmodule

// File: rtl/blk_lock_rdport.sv
module blk_lock_rdport #(
  parameter int NUM_BLOCKS = 12,
  parameter int ADDR_W     = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NUM_BLOCKS-1:0] lock_v,
  input  logic [NUM_BLOCKS-1:0] down_v,
  output logic                  lk_q,
  output logic                  ld_q
);
  logic [NUM_BLOCKS-1:0] hit;
  logic                  in_range;
  logic                  lk_n;
  logic                  ld_n;

  blk_lock_dec #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) dec_i (
    .addr    (addr),
    .hit     (hit),
    .in_range(in_range)
  );

  // AND-OR select; no block addressed reads as plain locked
  assign lk_n = in_range ? |(hit & lock_v) : 1'b1;
  assign ld_n = |(hit & down_v);

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_q <= 1'b1;
      ld_q <= 1'b0;
    end else begin
      lk_q <= lk_n;
      ld_q <= ld_n;
    end
  end
endmodule

// File: rtl/blk_lock_mgr.sv
module blk_lock_mgr #(
  parameter int NUM_BLOCKS = 12,
  parameter int ADDR_W     = 20,
  parameter int STAT_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_allow,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [STAT_W-1:0] rd_status
);
  logic [NUM_BLOCKS-1:0] cmd_hit;
  logic                  cmd_in_range;
  logic [NUM_BLOCKS-1:0] lock_v;
  logic [NUM_BLOCKS-1:0] down_v;
  logic                  chk_lk_q;
  logic                  chk_ld_q;
  logic                  rd_lk_q;
  logic                  rd_ld_q;

  blk_lock_dec #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) cmd_dec_i (
    .addr    (cmd_addr),
    .hit     (cmd_hit),
    .in_range(cmd_in_range)
  );

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_cell
    blk_lock_cell cell_i (
      .clk     (clk),
      .rst     (rst),
      .sel     (cmd_valid & cmd_hit[b]),
      .op      (cmd_op),
      .wp_n    (wp_n),
      .eff_lock(lock_v[b]),
      .down    (down_v[b])
    );
  end

  blk_lock_rdport #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) chk_port_i (
    .clk   (clk),
    .rst   (rst),
    .addr  (chk_addr),
    .lock_v(lock_v),
    .down_v(down_v),
    .lk_q  (chk_lk_q),
    .ld_q  (chk_ld_q)
  );

  blk_lock_rdport #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) rd_port_i (
    .clk   (clk),
    .rst   (rst),
    .addr  (rd_addr),
    .lock_v(lock_v),
    .down_v(down_v),
    .lk_q  (rd_lk_q),
    .ld_q  (rd_ld_q)
  );

  assign chk_allow = ~chk_lk_q;
  assign rd_status = {{(STAT_W-2){1'b0}}, rd_ld_q, rd_lk_q};

  logic unused_ok;
  assign unused_ok = &{1'b0, chk_ld_q, cmd_in_range};
endmodule

// File: rtl/blk_lock_mgr_chk.sv
module blk_lock_mgr_chk #(
  parameter int NUM_BLOCKS = 12,
  parameter int ADDR_W     = 20,
  parameter int STAT_W     = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wp_n,
  input logic [ADDR_W-1:0] chk_addr,
  input logic              chk_allow,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [STAT_W-1:0] rd_status
);
  localparam int IDX_W = $clog2(NUM_BLOCKS);

  logic chk_oor;
  assign chk_oor = int'(chk_addr[ADDR_W-1 -: IDX_W]) >= NUM_BLOCKS;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!chk_allow && rd_status == STAT_W'(1)));

  // R6
  down_forced_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_status[1] && !$past(wp_n)) |-> rd_status[0]);

  // R7
  down_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_status[1]) && !$past(rst) && $past(rd_addr) == $past(rd_addr, 2))
      |-> rd_status[1]);

  // R10
  oor_deny_chk: assert property (@(posedge clk) disable iff (rst)
    $past(chk_oor) |-> !chk_allow);

  // R12
  port_agree_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(chk_addr) == $past(rd_addr)) |-> (chk_allow == !rd_status[0]));
endmodule

bind blk_lock_mgr blk_lock_mgr_chk #(
  .NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .STAT_W(STAT_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .wp_n     (wp_n),
  .chk_addr (chk_addr),
  .chk_allow(chk_allow),
  .rd_addr  (rd_addr),
  .rd_status(rd_status)
);

// File: tb/blk_lock_mgr_tb_top.sv
module blk_lock_mgr_tb_top;
  localparam int NB     = 12;
  localparam int ADDR_W = 20;
  localparam int STAT_W = 16;
  localparam int IDX_W  = $clog2(NB);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic [1:0]        cmd_op = 2'd0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic              wp_n = 1'b0;
  logic [ADDR_W-1:0] chk_addr = '0;
  logic              chk_allow;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [STAT_W-1:0] rd_status;

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  blk_lock_mgr #(.NUM_BLOCKS(NB), .ADDR_W(ADDR_W), .STAT_W(STAT_W)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .wp_n(wp_n), .chk_addr(chk_addr),
    .chk_allow(chk_allow), .rd_addr(rd_addr), .rd_status(rd_status)
  );

  // behavioural reference model
  bit lk_m [NB];
  bit ld_m [NB];
  bit exp_allow;
  int exp_stat;
  bit have_exp = 0;

  function automatic int idx_of(logic [ADDR_W-1:0] a);
    return int'(a[ADDR_W-1 -: IDX_W]);
  endfunction

  function automatic logic [ADDR_W-1:0] addr_of(int blk);
    return (ADDR_W'(blk) << (ADDR_W - IDX_W)) | ADDR_W'(20'h00a5c);
  endfunction

  function automatic bit m_lock(int i);
    if (i >= NB) return 1'b1;
    return lk_m[i] || (ld_m[i] && !wp_n);
  endfunction

  function automatic bit m_down(int i);
    if (i >= NB) return 1'b0;
    return ld_m[i];
  endfunction

  always @(posedge clk) begin
    int ci;
    if (rst) begin
      foreach (lk_m[i]) begin
        lk_m[i] = 1'b1;
        ld_m[i] = 1'b0;
      end
      exp_allow = 1'b0;
      exp_stat  = 1;
    end else begin
      exp_allow = !m_lock(idx_of(chk_addr));
      exp_stat  = (int'(m_down(idx_of(rd_addr))) << 1) | int'(m_lock(idx_of(rd_addr)));
      ci = idx_of(cmd_addr);
      if (cmd_valid && ci < NB) begin
        case (cmd_op)
          2'd1: lk_m[ci] = 1'b1;
          2'd2: if (!ld_m[ci] || wp_n) lk_m[ci] = 1'b0;
          2'd3: begin lk_m[ci] = 1'b1; ld_m[ci] = 1'b1; end
          default: ;
        endcase
      end
    end
    have_exp = 1'b1;
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (have_exp) begin
      check(cur_req, "model chk_allow", int'(chk_allow), int'(exp_allow));
      check(cur_req, "model rd_status", int'(rd_status), exp_stat);
    end
  end

  task automatic send(int op, int blk);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 2'(op);
    cmd_addr  = addr_of(blk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 2'd0;
  endtask

  // directed check with literal expectations
  task automatic expect_blk(string req, int blk, int stat, bit allow);
    @(negedge clk);
    rd_addr  = addr_of(blk);
    chk_addr = addr_of(blk);
    @(negedge clk);
    check(req, $sformatf("status blk %0d", blk), int'(rd_status), stat);
    check(req, $sformatf("allow blk %0d", blk), int'(chk_allow), int'(allow));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    for (int b = 0; b < NB; b++) expect_blk("R1", b, 1, 1'b0);

    cur_req = "R2";
    send(2, 2);
    expect_blk("R2", 2, 0, 1'b1);
    send(1, 2);
    expect_blk("R2", 2, 1, 1'b0);
    send(2, 2);

    // request and query at the same edge see the old state
    cur_req = "R8";
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_addr = addr_of(3);
    chk_addr  = addr_of(3);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd0;
    check("R8", "same-edge query", int'(chk_allow), 0);
    @(negedge clk);
    check("R8", "next-edge query", int'(chk_allow), 1);

    cur_req = "R3";
    send(3, 5);
    expect_blk("R3", 5, 3, 1'b0);

    cur_req = "R4";
    send(2, 5);
    expect_blk("R4", 5, 3, 1'b0);

    cur_req = "R5";
    @(negedge clk); wp_n = 1'b1;
    send(2, 5);
    expect_blk("R5", 5, 2, 1'b1);
    send(1, 5);
    expect_blk("R5", 5, 3, 1'b0);
    send(2, 5);
    expect_blk("R5", 5, 2, 1'b1);

    cur_req = "R6";
    @(negedge clk); wp_n = 1'b0;
    expect_blk("R6", 5, 3, 1'b0);

    cur_req = "R7";
    send(1, 5);
    send(2, 5);
    expect_blk("R7", 5, 3, 1'b0);
    @(negedge clk); wp_n = 1'b1;
    send(2, 5);
    expect_blk("R7", 5, 2, 1'b1);
    do_reset();
    expect_blk("R7", 5, 1, 1'b0);
    @(negedge clk); wp_n = 1'b0;

    cur_req = "R9";
    send(2, 7);
    @(negedge clk);
    cmd_op = 2'd1; cmd_addr = addr_of(7);  // op present, strobe low
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0;       // strobe with no-op
    @(negedge clk);
    cmd_valid = 1'b0;
    expect_blk("R9", 7, 0, 1'b1);

    cur_req = "R10";
    send(2, 13);
    send(3, 14);
    expect_blk("R10", 13, 1, 1'b0);
    expect_blk("R10", 15, 1, 1'b0);
    expect_blk("R10", 1, 1, 1'b0);
    expect_blk("R10", 6, 1, 1'b0);

    cur_req = "R11";
    send(3, 0);
    @(negedge clk);
    rd_addr = addr_of(0) ^ ADDR_W'(20'h00fff);  // low bits differ
    @(negedge clk);
    check("R11", "low bits ignored", int'(rd_status), 3);
    check("R11", "upper bits zero", int'(rd_status[STAT_W-1:2]), 0);

    cur_req = "R12";
    @(negedge clk);
    chk_addr = addr_of(7);
    rd_addr  = addr_of(0);
    @(negedge clk);
    check("R12", "chk port independent", int'(chk_allow), 1);
    check("R12", "rd port independent", int'(rd_status), 3);

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule